// File: doc/BRIEF.md
# Chip-Select Output Control Unit

This block drives a bank of general-purpose output pins, each of which may serve as a chip-select line for an external peripheral. Each line has an output latch. A configuration register holds, for every line, a chip-select-mode flag and an output-invert flag. The pin driven for a line is its latch value XOR its invert flag, taken through one register stage.

Software changes the latches through a force register. Its write word is split in two halves. A 1 in the upper half sets the matching latch, and a 1 in the lower half clears it. Bits written as 0 leave their latches alone. This lets a single write assert or release a select line without a read-modify-write, so two agents can share the bank safely. A status register reads back the latch states. An active-high select is made by setting the line's invert flag.

Top module: `cs_out_ctl`

## Requirements
- R1: After reset every latch reads 1, the configuration register reads 0, and every pin is 1.
- R2: A force write (address 1) with bit n+N at 1 and bit n at 0 sets latch n.
- R3: A force write with bit n at 1 and bit n+N at 0 clears latch n.
- R4: In a force write, a line whose set bit and clear bit are both 0 keeps its latch value.
- R5: In a force write, a line whose set bit and clear bit are both 1 keeps its latch value.
- R6: Pin n equals latch n XOR invert bit n. The pin takes the new value on the clock edge after the edge that wrote the latch or the invert bit.
- R7: A configuration write (address 0) stores chip-select-mode flags in bits 2N-1..N and invert flags in bits N-1..0. Reading address 0 returns them unchanged.
- R8: Reading status (address 2) returns the latches in bits N-1..0 and 0 above. Reading the force address, or reading with bus_sel low, returns 0.
- R9: A cycle without both bus_sel and bus_wr high, or a write to address 3, changes neither the latches nor the configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Register address: 0 config, 1 force, 2 status |
| bus_wdata | input | 2*N | Write data |
| bus_rdata | output | 2*N | Combinational read data |
| pin_out | output | N | Registered output pins |

## Verification
A corrupted latch shows up in the status read on the cycle after the offending write, and on the pins one edge later. A corrupted invert flag shows up only at the pins and in the configuration readback, so both are compared after every write. A set/clear mix-up in the split word leaves the wrong latch state that is visible at once. Stimulus therefore covers set-only, clear-only, zero and set-plus-clear patterns on the same lines.

// File: rtl/cs_out_ctl.sv
module cs_out_ctl #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [1:0]     bus_addr,
  input  logic [2*N-1:0] bus_wdata,
  output logic [2*N-1:0] bus_rdata,
  output logic [N-1:0]   pin_out
);
  localparam logic [1:0] A_CFG   = 2'd0;
  localparam logic [1:0] A_FORCE = 2'd1;
  localparam logic [1:0] A_STAT  = 2'd2;

  logic [N-1:0] lat_q, inv_q, csen_q;
  logic [N-1:0] set_m, clr_m;
  logic         wr_cfg, wr_force;

  assign wr_cfg   = bus_sel && bus_wr && (bus_addr == A_CFG);
  assign wr_force = bus_sel && bus_wr && (bus_addr == A_FORCE);
  assign set_m    = bus_wdata[2*N-1:N];
  assign clr_m    = bus_wdata[N-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '1;
      inv_q  <= '0;
      csen_q <= '0;
    end else begin
      if (wr_force) lat_q <= (lat_q & ~(clr_m & ~set_m)) | (set_m & ~clr_m);
      if (wr_cfg) begin
        csen_q <= bus_wdata[2*N-1:N];
        inv_q  <= bus_wdata[N-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_out <= '1;
    else        pin_out <= lat_q ^ inv_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_CFG:   bus_rdata = {csen_q, inv_q};
        A_STAT:  bus_rdata = {{N{1'b0}}, lat_q};
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

module cs_out_ctl_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_sel,
  input logic           bus_wr,
  input logic [1:0]     bus_addr,
  input logic [2*N-1:0] bus_wdata,
  input logic [N-1:0]   lat,
  input logic [N-1:0]   inv,
  input logic [N-1:0]   csen,
  input logic [N-1:0]   pin_out
);
  logic fw;
  assign fw = bus_sel && bus_wr && (bus_addr == 2'd1);

  // R2
  force_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fw |=> ((lat & $past(bus_wdata[2*N-1:N] & ~bus_wdata[N-1:0])) == $past(bus_wdata[2*N-1:N] & ~bus_wdata[N-1:0])));

  // R3
  force_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fw |=> ((lat & $past(bus_wdata[N-1:0] & ~bus_wdata[2*N-1:N])) == '0));

  // R4 R5
  force_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fw |=> (((lat ^ $past(lat)) & ~$past(bus_wdata[2*N-1:N] ^ bus_wdata[N-1:0])) == '0));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr != 2'd3) |=> ($stable(lat) && $stable(inv) && $stable(csen)));

  // R6
  pin_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pin_out == $past(lat ^ inv)));
endmodule

bind cs_out_ctl cs_out_ctl_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .lat(lat_q), .inv(inv_q), .csen(csen_q), .pin_out(pin_out)
);

// File: tb/cs_out_ctl_tb.sv
module cs_out_ctl_tb;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [2*N-1:0] bus_wdata = 0;
  logic [2*N-1:0] bus_rdata;
  logic [N-1:0] pin_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cs_out_ctl #(.N(N)) u_dut (.*);

  // {addr, wdata, expected status, expected pins}
  localparam logic [33:0] VEC [10] = '{
    {2'd1, 16'h0001, 8'hFE, 8'hFE},  // R3 clear line 0
    {2'd1, 16'h00F0, 8'hFE & 8'h0F, 8'h0E},  // R3 clear 4..7
    {2'd1, 16'h0300, 8'h0F, 8'h0F},  // R2 set 0,1
    {2'd1, 16'h0000, 8'h0F, 8'h0F},  // R4 nothing
    {2'd1, 16'h8080, 8'h0F, 8'h0F},  // R5 set+clear line 7
    {2'd0, 16'h00FF, 8'h0F, 8'hF0},  // R6 invert all
    {2'd1, 16'hF000, 8'hFF, 8'h00},  // R2 set 4..7
    {2'd0, 16'hAA55, 8'hFF, 8'hAA},  // R6 R7 partial invert
    {2'd1, 16'h0081, 8'h7E, 8'h2B},  // R3 clear 0,7
    {2'd1, 16'h8100, 8'hFF, 8'hAA}   // R2 set 0,7
  };

  task automatic chk(string req, logic [2*N-1:0] act, logic [2*N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [2*N-1:0] d, logic strobe);
    @(negedge clk);
    bus_sel = 1; bus_wr = strobe; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    @(negedge clk);
  endtask

  task automatic rd(logic [1:0] a, output logic [2*N-1:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
    #1;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2*N-1:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(2'd2, r); chk("R1 status", r, 16'h00FF);
    rd(2'd0, r); chk("R1 config", r, 16'h0000);
    chk("R1 pins", {8'h00, pin_out}, 16'h00FF);

    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][33:32], VEC[i][31:16], 1'b1);
      rd(2'd2, r); chk("R2-R6 vector status", r, {8'h00, VEC[i][15:8]});
      chk("R6 vector pins", {8'h00, pin_out}, {8'h00, VEC[i][7:0]});
    end

    rd(2'd0, r); chk("R7 config readback", r, 16'hAA55);
    rd(2'd1, r); chk("R8 force reads zero", r, 16'h0000);
    bus_addr = 2'd2; #1 chk("R8 no select reads zero", bus_rdata, 16'h0000);

    wr(2'd1, 16'h00FF, 1'b0);
    rd(2'd2, r); chk("R9 no strobe latches", r, 16'h00FF);
    wr(2'd0, 16'h1234, 1'b0);
    rd(2'd0, r); chk("R9 no strobe config", r, 16'hAA55);
    wr(2'd3, 16'h00FF, 1'b1);
    rd(2'd2, r); chk("R9 unmapped latches", r, 16'h00FF);
    rd(2'd0, r); chk("R9 unmapped config", r, 16'hAA55);
    chk("R9 pins", {8'h00, pin_out}, 16'h00AA);

    wr(2'd0, 16'h3C00, 1'b1);
    rd(2'd0, r); chk("R7 csen only", r, 16'h3C00);
    chk("R6 invert cleared", {8'h00, pin_out}, 16'h00FF);

    // R6 timing: pin unchanged right after the latch edge
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 2'd1; bus_wdata = 16'h0002;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    chk("R6 pin before delay", {8'h00, pin_out}, 16'h00FF);
    rd(2'd2, r); chk("R3 immediate status", r, 16'h00FD);
    @(negedge clk);
    chk("R6 pin after delay", {8'h00, pin_out}, 16'h00FD);

    rst_n = 0; #3;
    rd(2'd2, r); chk("R1 mid reset status", r, 16'h00FF);
    rd(2'd0, r); chk("R1 mid reset config", r, 16'h0000);
    chk("R1 mid reset pins", {8'h00, pin_out}, 16'h00FF);
    @(negedge clk); rst_n = 1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule